// File: doc/BRIEF.md
# Training and Skip Ordered-Set Transmitter

This block feeds symbols to the lanes of a multi-lane serial link on the transmit side. The link training state machine asks for a kind of training sequence (first training set, second training set, or fast-training set). The block sends that set on every lane in the same cycle. In each training set it fills the link and lane fields per lane: either with a PAD code or with the configured link number and that lane's own lane number.

Between ordered sets, the block passes link-layer traffic to the lanes one symbol per lane per cycle. A programmable interval timer schedules skip ordered sets. A skip that falls due while a packet is in flight waits until the packet ends. A due skip beats both a pending training request and a new packet start, and the link layer is held off through its ready signal while the skip goes out. When nothing is due, the lanes carry idle data.

The block produces the symbols and their control flags only. Line encoding and serialisation happen downstream.

Top module: `os_lane_tx`

## Requirements
- R1: The first symbol of every ordered set is COM (0xBC, control flag set), and it appears on all lanes in the same cycle.
- R2: The request code is 0 for none, 1 for training set one, 2 for training set two and 3 for fast-training. A training set lasts 16 cycles. Its symbols in order are COM, the link field, the lane field, the `nfts` value, 0x02 and 0x00, followed by ten identifier symbols. The identifier is 0x4A for set one and 0x45 for set two. Every symbol after COM carries a clear control flag unless it is PAD.
- R3: While `pad_all` is high, the link field and the lane field of a training set are PAD (0xF7, control flag set) on every lane.
- R4: While no PAD applies to a lane, its link field carries `link_num` and its lane field carries that lane's own 5-bit `lane_num` slice, zero-extended, both with the control flag clear.
- R5: A set `lane_pad` bit forces PAD into both fields of that lane only. Other lanes keep their numbers.
- R6: A request is sampled only at a set boundary. A change of request in the middle of a set has no effect until that set completes. A request held high produces back-to-back sets with no gap.
- R7: A fast-training set is COM followed by three FTS symbols (0x3C, control flag set).
- R8: With a nonzero `skp_interval` N, the skip timer expires once every N cycles and marks a skip as pending. A skip set is COM followed by three SKP symbols (0x1C, control flag set). An interval of 0 stops all skips.
- R9: A skip set never starts between an accepted start-of-packet and its end-of-packet. At most one skip is pending at a time. If an expiry falls in the same cycle that a pending skip starts, a new skip becomes pending.
- R10: At a boundary, a pending skip goes before a training request, and a training request goes before link data. `dl_ready` is high only at a boundary while a packet is open, or when neither a skip nor a request is waiting.
- R11: A symbol accepted from the link layer (`dl_valid` and `dl_ready` both high) appears on the lanes on the next cycle with the control flag clear. With nothing to send, every lane carries 0x00 with the flag clear.
- R12: All lane outputs are registered with one cycle of latency. `tx_valid` is low during reset and high on every lane once the block runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| os_req | input | 2 | Ordered-set request: 0 none, 1 training set one, 2 training set two, 3 fast-training |
| pad_all | input | 1 | Put PAD in the link and lane fields on all lanes |
| lane_pad | input | NLANE | Per-lane PAD override for lanes disabled during training |
| lane_num | input | NLANE*LNW | Lane number of each lane, lane 0 in the lowest slice |
| link_num | input | 8 | Link number placed in the link field |
| nfts | input | 8 | Fast-training count placed in symbol 3 of a training set |
| skp_interval | input | CNT_W | Skip interval in cycles; 0 disables skips |
| dl_data | input | NLANE*8 | Link-layer symbols, lane 0 in the lowest byte |
| dl_valid | input | 1 | Link-layer symbol available |
| dl_sop | input | 1 | Start of packet, qualified by dl_valid |
| dl_eop | input | 1 | End of packet, qualified by dl_valid |
| dl_ready | output | 1 | Block takes the link-layer symbol this cycle |
| tx_sym | output | NLANE*8 | Symbol per lane |
| tx_ctl | output | NLANE | Control-symbol flag per lane |
| tx_valid | output | NLANE | Lane output valid |

## Verification
The bench targets skip expiries that land inside a long packet. A design that cut the packet would show SKP symbols between data beats. A design that queued expiries would send two skip sets in a row after the end of the packet. It also changes the training request in the middle of a set, which a design that samples the request too early would answer with a set that mixes the two identifiers. A lane with PAD forced is checked against its unforced neighbours, so an override applied to the wrong lane, or one that leaks to all lanes, shows up at once. Finally, a held request is interleaved with due skips: a design with the wrong order of precedence would delay the skip, and one with a wrong ready term would either lose link data or accept it in the middle of a set.

// File: rtl/os_tx_pkg.sv
package os_tx_pkg;
  localparam logic [7:0] K_COM   = 8'hBC;
  localparam logic [7:0] K_SKP   = 8'h1C;
  localparam logic [7:0] K_FTS   = 8'h3C;
  localparam logic [7:0] K_PAD   = 8'hF7;
  localparam logic [7:0] D_IDLE  = 8'h00;
  localparam logic [7:0] ID_TS1  = 8'h4A;
  localparam logic [7:0] ID_TS2  = 8'h45;
  localparam logic [7:0] RATE_ID = 8'h02;
  localparam logic [7:0] TRN_CTL = 8'h00;

  localparam int TS_LEN    = 16;
  localparam int SHORT_LEN = 4;
  localparam int IDX_W     = $clog2(TS_LEN);

  typedef enum logic [1:0] {REQ_NONE, REQ_TS1, REQ_TS2, REQ_FTS} os_req_e;
  typedef enum logic [2:0] {SEL_IDLE, SEL_DATA, SEL_SKP, SEL_TS1, SEL_TS2, SEL_FTS} sel_e;
  typedef enum logic [2:0] {ST_BND, ST_SKP, ST_TS1, ST_TS2, ST_FTS} seq_st_e;
endpackage

// File: rtl/os_skp_timer.sv
module os_skp_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] interval,
  input  logic             skp_start,
  output logic             skp_pend
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pend_q, pend_n;
  logic             run_en;
  logic             expire;

  always_comb begin
    run_en = (interval != '0);
    expire = run_en && (cnt_q == interval - 1'b1);
    if (!run_en)     cnt_n = '0;
    else if (expire) cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
    // a fresh expiry wins over the start that consumes the old one
    if (expire)         pend_n = 1'b1;
    else if (skp_start) pend_n = 1'b0;
    else                pend_n = pend_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  assign skp_pend = pend_q;
endmodule

// File: rtl/os_seq_ctrl.sv
module os_seq_ctrl
  import os_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  os_req_e          req,
  input  logic             skp_pend,
  input  logic             dl_valid,
  input  logic             dl_sop,
  input  logic             dl_eop,
  output sel_e             sel,
  output logic [IDX_W-1:0] idx,
  output logic             skp_start,
  output logic             dl_ready
);
  localparam logic [IDX_W-1:0] TS_LAST    = IDX_W'(TS_LEN - 1);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LEN - 1);

  seq_st_e          st_q, st_n;
  logic [IDX_W-1:0] cnt_q, cnt_n;
  logic             pkt_q, pkt_n;

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    pkt_n     = pkt_q;
    sel       = SEL_IDLE;
    idx       = cnt_q;
    skp_start = 1'b0;
    dl_ready  = (st_q == ST_BND) && (pkt_q || (!skp_pend && req == REQ_NONE));
    case (st_q)
      ST_BND: begin
        idx = '0;
        if (!pkt_q && skp_pend) begin
          sel       = SEL_SKP;
          skp_start = 1'b1;
          st_n      = ST_SKP;
          cnt_n     = IDX_W'(1);
        end else if (!pkt_q && req != REQ_NONE) begin
          cnt_n = IDX_W'(1);
          case (req)
            REQ_TS1: begin sel = SEL_TS1; st_n = ST_TS1; end
            REQ_TS2: begin sel = SEL_TS2; st_n = ST_TS2; end
            default: begin sel = SEL_FTS; st_n = ST_FTS; end
          endcase
        end else if (dl_valid) begin
          sel = SEL_DATA;
          if (dl_eop)      pkt_n = 1'b0;
          else if (dl_sop) pkt_n = 1'b1;
        end
      end
      ST_SKP, ST_FTS: begin
        sel = (st_q == ST_SKP) ? SEL_SKP : SEL_FTS;
        if (cnt_q == SHORT_LAST) begin
          st_n  = ST_BND;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_TS1, ST_TS2: begin
        sel = (st_q == ST_TS1) ? SEL_TS1 : SEL_TS2;
        if (cnt_q == TS_LAST) begin
          st_n  = ST_BND;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: st_n = ST_BND;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_BND;
      cnt_q <= '0;
      pkt_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      pkt_q <= pkt_n;
    end
  end
endmodule

// File: rtl/os_lane_sym.sv
module os_lane_sym
  import os_tx_pkg::*;
#(
  parameter int LNW = 5
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  sel_e             sel,
  input  logic [IDX_W-1:0] idx,
  input  logic             pad,
  input  logic [7:0]       link_num,
  input  logic [LNW-1:0]   lane_num,
  input  logic [7:0]       nfts,
  input  logic [7:0]       data,
  output logic [7:0]       sym,
  output logic             ctl,
  output logic             vld
);
  logic [7:0] sym_n;
  logic       ctl_n;

  always_comb begin
    sym_n = D_IDLE;
    ctl_n = 1'b0;
    case (sel)
      SEL_DATA: sym_n = data;
      SEL_SKP: begin
        sym_n = (idx == '0) ? K_COM : K_SKP;
        ctl_n = 1'b1;
      end
      SEL_FTS: begin
        sym_n = (idx == '0) ? K_COM : K_FTS;
        ctl_n = 1'b1;
      end
      SEL_TS1, SEL_TS2: begin
        case (idx)
          IDX_W'(0): begin sym_n = K_COM; ctl_n = 1'b1; end
          IDX_W'(1): begin sym_n = pad ? K_PAD : link_num;    ctl_n = pad; end
          IDX_W'(2): begin sym_n = pad ? K_PAD : 8'(lane_num); ctl_n = pad; end
          IDX_W'(3): sym_n = nfts;
          IDX_W'(4): sym_n = RATE_ID;
          IDX_W'(5): sym_n = TRN_CTL;
          default:   sym_n = (sel == SEL_TS1) ? ID_TS1 : ID_TS2;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sym <= '0;
      ctl <= 1'b0;
      vld <= 1'b0;
    end else begin
      sym <= sym_n;
      ctl <= ctl_n;
      vld <= 1'b1;
    end
  end
endmodule

// File: rtl/os_lane_tx.sv
module os_lane_tx
  import os_tx_pkg::*;
#(
  parameter int NLANE = 4,
  parameter int LNW   = 5,
  parameter int CNT_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           os_req,
  input  logic                 pad_all,
  input  logic [NLANE-1:0]     lane_pad,
  input  logic [NLANE*LNW-1:0] lane_num,
  input  logic [7:0]           link_num,
  input  logic [7:0]           nfts,
  input  logic [CNT_W-1:0]     skp_interval,
  input  logic [NLANE*8-1:0]   dl_data,
  input  logic                 dl_valid,
  input  logic                 dl_sop,
  input  logic                 dl_eop,
  output logic                 dl_ready,
  output logic [NLANE*8-1:0]   tx_sym,
  output logic [NLANE-1:0]     tx_ctl,
  output logic [NLANE-1:0]     tx_valid
);
  logic [1:0]       rst_sync;
  logic             rst_s;
  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic             skp_start;
  logic             skp_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  os_skp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_ni    (rst_s),
    .interval  (skp_interval),
    .skp_start (skp_start),
    .skp_pend  (skp_pend)
  );

  os_seq_ctrl u_seq (
    .clk       (clk),
    .rst_ni    (rst_s),
    .req       (os_req_e'(os_req)),
    .skp_pend  (skp_pend),
    .dl_valid  (dl_valid),
    .dl_sop    (dl_sop),
    .dl_eop    (dl_eop),
    .sel       (sel),
    .idx       (idx),
    .skp_start (skp_start),
    .dl_ready  (dl_ready)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    os_lane_sym #(.LNW(LNW)) u_lane (
      .clk      (clk),
      .rst_ni   (rst_s),
      .sel      (sel),
      .idx      (idx),
      .pad      (pad_all | lane_pad[g]),
      .link_num (link_num),
      .lane_num (lane_num[g*LNW +: LNW]),
      .nfts     (nfts),
      .data     (dl_data[g*8 +: 8]),
      .sym      (tx_sym[g*8 +: 8]),
      .ctl      (tx_ctl[g]),
      .vld      (tx_valid[g])
    );
  end
endmodule

// File: rtl/os_lane_tx_chk.sv
module os_lane_tx_chk
  import os_tx_pkg::*;
#(
  parameter int NLANE = 4
) (
  input logic               clk,
  input logic               rst_s,
  input logic               dl_valid,
  input logic               dl_ready,
  input logic               dl_sop,
  input logic               dl_eop,
  input logic [NLANE*8-1:0] dl_data,
  input logic [NLANE*8-1:0] tx_sym,
  input logic [NLANE-1:0]   tx_ctl,
  input logic [NLANE-1:0]   tx_valid
);
  logic pkt_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) pkt_q <= 1'b0;
    else if (dl_valid && dl_ready) begin
      if (dl_eop)      pkt_q <= 1'b0;
      else if (dl_sop) pkt_q <= 1'b1;
    end
  end

  p_com_all_lanes_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (tx_ctl[0] && tx_sym[7:0] == K_COM) |-> (tx_sym == {NLANE{K_COM}} && (&tx_ctl)));

  p_skp_outside_pkt_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (tx_ctl[0] && tx_sym[7:0] == K_SKP) |-> !pkt_q);

  p_skp_holds_ready_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (tx_ctl[0] && tx_sym[7:0] == K_SKP) |-> !$past(dl_ready));

  p_data_pass_r11: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && $past(dl_valid && dl_ready)) |-> (tx_sym == $past(dl_data) && tx_ctl == '0));

  p_valid_run_r12: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) |-> (&tx_valid));
endmodule

bind os_lane_tx os_lane_tx_chk #(.NLANE(NLANE)) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .dl_valid (dl_valid),
  .dl_ready (dl_ready),
  .dl_sop   (dl_sop),
  .dl_eop   (dl_eop),
  .dl_data  (dl_data),
  .tx_sym   (tx_sym),
  .tx_ctl   (tx_ctl),
  .tx_valid (tx_valid)
);

// File: tb/sim_os_lane_tx.sv
module sim_os_lane_tx;
  localparam int NL  = 4;
  localparam int LW  = 5;
  localparam int CW  = 12;

  typedef struct {
    logic [NL*8-1:0] s;
    logic [NL-1:0]   c;
    string           tag;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic [1:0]       rq;
  logic             padall;
  logic [NL-1:0]    lpad;
  logic [NL*LW-1:0] lnum;
  logic [7:0]       link;
  logic [7:0]       nfts;
  logic [CW-1:0]    ivl;
  logic [NL*8-1:0]  dd;
  logic             dv, sop, eop;
  logic             dl_ready;
  logic [NL*8-1:0]  tx_sym;
  logic [NL-1:0]    tx_ctl;
  logic [NL-1:0]    tx_valid;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t q[$];

  int m_st, m_cnt, m_tc;
  bit m_pkt, m_pend;

  os_lane_tx #(.NLANE(NL), .LNW(LW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .os_req(rq), .pad_all(padall), .lane_pad(lpad),
    .lane_num(lnum), .link_num(link), .nfts(nfts), .skp_interval(ivl),
    .dl_data(dd), .dl_valid(dv), .dl_sop(sop), .dl_eop(eop), .dl_ready(dl_ready),
    .tx_sym(tx_sym), .tx_ctl(tx_ctl), .tx_valid(tx_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // sel: 0 idle, 1 data, 2 skip, 3 set one, 4 set two, 5 fast-training
  function automatic logic [8:0] mk(int sel, int idx, int ln);
    bit pd;
    pd = padall | lpad[ln];
    case (sel)
      0: return 9'h000;
      1: return {1'b0, dd[ln*8 +: 8]};
      2: return (idx == 0) ? {1'b1, 8'hBC} : {1'b1, 8'h1C};
      5: return (idx == 0) ? {1'b1, 8'hBC} : {1'b1, 8'h3C};
      default: begin
        case (idx)
          0: return {1'b1, 8'hBC};
          1: return pd ? {1'b1, 8'hF7} : {1'b0, link};
          2: return pd ? {1'b1, 8'hF7} : {1'b0, 8'(ln * 2 + 1)};
          3: return {1'b0, nfts};
          4: return 9'h002;
          5: return 9'h000;
          default: return (sel == 3) ? 9'h04A : 9'h045;
        endcase
      end
    endcase
  endfunction

  task automatic step(input string tag, output bit acc);
    int sel = 0;
    int idx = 0;
    bit rdy, start, expire;
    exp_t e;
    start  = 0;
    expire = 0;
    #1;
    rdy = (m_st == 0) && (m_pkt || (!m_pend && rq == 2'd0));
    chk(dl_ready === rdy, "R10", "dl_ready", 64'(dl_ready), 64'(rdy));
    acc = 0;
    case (m_st)
      0: begin
        if (!m_pkt && m_pend) begin
          sel = 2; start = 1; m_st = 1; m_cnt = 1;
        end else if (!m_pkt && rq != 2'd0) begin
          sel  = (rq == 2'd1) ? 3 : (rq == 2'd2) ? 4 : 5;
          m_st = (rq == 2'd1) ? 2 : (rq == 2'd2) ? 3 : 4;
          m_cnt = 1;
        end else if (dv) begin
          sel = 1; acc = 1;
          if (eop) m_pkt = 0;
          else if (sop) m_pkt = 1;
        end
      end
      1, 4: begin
        sel = (m_st == 1) ? 2 : 5;
        idx = m_cnt;
        if (m_cnt == 3) begin m_st = 0; m_cnt = 0; end
        else m_cnt++;
      end
      default: begin
        sel = m_st + 1;
        idx = m_cnt;
        if (m_cnt == 15) begin m_st = 0; m_cnt = 0; end
        else m_cnt++;
      end
    endcase
    if (ivl != 0) begin
      if (m_tc == int'(ivl) - 1) begin m_tc = 0; expire = 1; end
      else m_tc++;
    end else m_tc = 0;
    if (expire) m_pend = 1;
    else if (start) m_pend = 0;
    for (int l = 0; l < NL; l++) begin
      logic [8:0] v;
      v = mk(sel, idx, l);
      e.s[l*8 +: 8] = v[7:0];
      e.c[l]        = v[8];
    end
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(input string tag, input int n);
    bit a;
    for (int i = 0; i < n; i++) step(tag, a);
  endtask

  task automatic packet(input string tag, input int len, input int base);
    bit a;
    for (int b = 0; b < len; b++) begin
      for (int l = 0; l < NL; l++) dd[l*8 +: 8] = 8'(base + b * 8 + l + 1);
      dv  = 1'b1;
      sop = (b == 0);
      eop = (b == len - 1);
      do step(tag, a); while (!a);
    end
    dv = 1'b0; sop = 1'b0; eop = 1'b0; dd = '0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        for (int l = 0; l < NL; l++) begin
          chk(tx_sym[l*8 +: 8] === e.s[l*8 +: 8] && tx_ctl[l] === e.c[l], e.tag,
              $sformatf("lane %0d symbol/flag", l),
              64'({tx_ctl[l], tx_sym[l*8 +: 8]}), 64'({e.c[l], e.s[l*8 +: 8]}));
        end
        chk(tx_valid === '1, "R12", "tx_valid", 64'(tx_valid), 64'({NL{1'b1}}));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rq = 2'd0; padall = 1'b0; lpad = '0; link = 8'h5A; nfts = 8'h1F;
    ivl = '0; dd = '0; dv = 1'b0; sop = 1'b0; eop = 1'b0;
    for (int l = 0; l < NL; l++) lnum[l*LW +: LW] = LW'(l * 2 + 1);
    m_st = 0; m_cnt = 0; m_tc = 0; m_pkt = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(tx_valid === '0, "R12", "tx_valid in reset", 64'(tx_valid), 64'h0);
    chk(tx_sym === '0 && tx_ctl === '0, "R12", "tx_sym in reset", 64'(tx_sym), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    run("R11", 4);                        // idle D0.0
    packet("R11", 5, 8'h10);              // passthrough
    run("R11", 2);

    rq = 2'd1;                            // set one, own numbers
    run("R4", 16);
    lpad = 4'b0100;                       // one lane forced
    run("R5", 16);
    lpad = '0; padall = 1'b1; rq = 2'd2;  // set two with PAD everywhere
    run("R3", 16);
    padall = 1'b0; rq = 2'd1;
    run("R6", 5);                         // switch mid-set
    rq = 2'd2;
    run("R6", 27);
    rq = 2'd0;
    run("R2", 3);
    rq = 2'd3;
    run("R7", 4);
    rq = 2'd0;
    run("R7", 2);

    ivl = CW'(12);
    run("R8", 30);
    packet("R9", 30, 8'h40);              // expiries fall inside packet
    run("R9", 6);
    rq = 2'd1;
    run("R10", 40);                       // skips interleave with held request
    rq = 2'd0;
    packet("R10", 6, 8'h80);
    run("R1", 20);
    ivl = '0;
    run("R8", 20);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule